// File: doc/BRIEF.md
# Floating-Point Compare Unit

This unit executes the two compare instructions of a 16-bit-encoded RISC core's floating-point pipe. A one-cycle `start` strobe hands it an instruction word, a precision-mode bit and two operand values that the register file has already read. In single mode the unit compares the low 32 bits of each operand bus as IEEE-754 single values. In double mode it compares the full 64-bit buses as IEEE-754 double values. The instruction selects either an equality test or a strict greater-than test, and the outcome goes to a one-bit condition flag.

Single compares finish one cycle after the strobe. Double compares take a second cycle, and the operands are latched at the strobe. Each compare clears the invalid-operation cause bit. A compare raises the cause again when NaN operands make it invalid, under a rule that differs between the two compare kinds. Whether the invalid case traps depends on an enable input. With the trap enabled, the unit requests an exception and leaves the flag alone. With the trap disabled, it records the event in a sticky bit and writes a false flag.

Top module: `fp_compare_unit`

## Requirements
- R1: With `prec_dbl`=0 the compare uses `op_n[31:0]` and `op_m[31:0]` as singles (8-bit exponent, 23-bit fraction), and the upper bits have no effect. With `prec_dbl`=1 it uses all 64 bits as doubles (11-bit exponent, 52-bit fraction).
- R2: A start is accepted only when `opcode[15:12]`=4'b1111 and `opcode[3:0]` is 4'b0100 (equality) or 4'b0101 (greater-than). `opcode[11:8]` names operand n and `opcode[7:4]` names operand m. Any other opcode is ignored: `done` stays low and all outputs keep their values.
- R3: In double mode, a start with `opcode[8]`=1 or `opcode[4]`=1 (odd register) is ignored, in the same way as in R2.
- R4: `done` is high for exactly one cycle for each accepted compare. For a single compare this is the cycle after the start edge. For a double compare it is the cycle after that, and the operands are sampled at the start edge.
- R5: Equality gives `tflag`=1 when n and m are numerically equal. +0 equals -0. Denormals are compared exactly.
- R6: Greater-than gives `tflag`=1 only when n > m. The test is sign-magnitude: it reverses order for two negatives, and +0 is not greater than -0.
- R7: A quiet NaN (exponent all ones, fraction MSB 1) gives `tflag`=0 with no invalid for equality, and is invalid for greater-than.
- R8: A signalling NaN (exponent all ones, fraction MSB 0, fraction nonzero) in either operand is invalid for both compare kinds.
- R9: On invalid with `inv_trap_en`=0, the unit writes `tflag`=0, `cause_invalid`=1 and `sticky_invalid`=1, and `exc_req` stays low. The sticky bit clears only on reset.
- R10: On invalid with `inv_trap_en`=1 (sampled in the `done` cycle's edge), `tflag` is unchanged, `cause_invalid`=1, `exc_req` pulses together with `done`, and `sticky_invalid` is unchanged.
- R11: An accepted start clears `cause_invalid`. A compare that is not invalid ends with it at 0. During the second cycle of a double compare it reads 0.
- R12: A start that arrives while a double compare is in progress is ignored.
- R13: After reset, `done`, `tflag`, `cause_invalid`, `sticky_invalid` and `exc_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Issue strobe for one compare |
| opcode | input | 16 | Instruction word |
| prec_dbl | input | 1 | Precision mode: 0 single, 1 double |
| op_n | input | 64 | Operand n (first) |
| op_m | input | 64 | Operand m (second) |
| inv_trap_en | input | 1 | Invalid-operation trap enable |
| done | output | 1 | Result written this cycle |
| tflag | output | 1 | Condition flag |
| cause_invalid | output | 1 | Invalid cause of the latest compare |
| sticky_invalid | output | 1 | Accumulated invalid flag |
| exc_req | output | 1 | Exception request pulse |

## Verification
A wrong busy state shows up at the ports within two cycles. A stuck busy bit swallows the next compare, so `done` never appears. A busy bit that clears too early gives a second `done` or a result computed from live operands instead of latched ones. A misclassified NaN or a wrong sign-magnitude branch flips `tflag` or `cause_invalid` in the very `done` cycle of the compare that hits it. The bench therefore checks `tflag`, the cause bit, the sticky bit and `exc_req` at that cycle. It also checks that `done` is low in the cycles before and after it.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    localparam int OPC_W      = 16;
    localparam int DATA_W     = 64;
    localparam int SGL_EXP_W  = 8;
    localparam int SGL_FRAC_W = 23;
    localparam int DBL_EXP_W  = 11;
    localparam int DBL_FRAC_W = 52;
    localparam int NUM_FMT    = 2;

    typedef enum logic {
        CMP_EQ = 1'b0,
        CMP_GT = 1'b1
    } cmp_kind_e;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
    } fclass_t;

    typedef struct packed {
        cmp_kind_e           kind;
        logic                dbl;
        logic [DATA_W-1:0]   a;
        logic [DATA_W-1:0]   b;
    } cmp_job_t;

    typedef struct packed {
        logic invalid;
        logic t;
    } cmp_res_t;

    function automatic logic op_is_cmp(input logic [OPC_W-1:0] op);
        return (op[15:12] == 4'hF) && (op[3:1] == 3'b010);
    endfunction

    function automatic cmp_kind_e op_kind(input logic [OPC_W-1:0] op);
        return op[0] ? CMP_GT : CMP_EQ;
    endfunction

    function automatic logic regs_even(input logic [OPC_W-1:0] op);
        return !op[8] && !op[4];
    endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] x,
    output fclass_t               cls
);
    localparam int W = EXP_W + FRAC_W + 1;

    logic              exp_max;
    logic [FRAC_W-1:0] frac;

    always_comb begin
        exp_max     = &x[W-2 -: EXP_W];
        frac        = x[FRAC_W-1:0];
        cls.is_nan  = exp_max && (|frac);
        cls.is_snan = exp_max && (|frac) && !frac[FRAC_W-1];
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         gt,
    output logic         eq
);
    logic         sa, sb;
    logic [W-2:0] ma, mb;
    logic         zeros;

    always_comb begin
        sa    = a[W-1];
        sb    = b[W-1];
        ma    = a[W-2:0];
        mb    = b[W-2:0];
        zeros = (ma == '0) && (mb == '0);
        eq    = zeros || (a == b);
        if (sa != sb)
            gt = !sa && !zeros;
        else if (!sa)
            gt = ma > mb;
        else
            gt = ma < mb;
    end
endmodule

// File: rtl/fcmp_eval.sv
module fcmp_eval
    import fcmp_pkg::*;
(
    input  cmp_job_t job,
    output cmp_res_t res
);
    logic [NUM_FMT-1:0] nan_any, snan_any, gt_f, eq_f;

    for (genvar f = 0; f < NUM_FMT; f++) begin : g_fmt
        localparam int EW = (f == 0) ? SGL_EXP_W  : DBL_EXP_W;
        localparam int FW = (f == 0) ? SGL_FRAC_W : DBL_FRAC_W;
        localparam int W  = EW + FW + 1;

        fclass_t cls_a, cls_b;
        logic    gt_w, eq_w;

        fcmp_classify #(.EXP_W(EW), .FRAC_W(FW)) u_cls_a (
            .x   (job.a[W-1:0]),
            .cls (cls_a)
        );
        fcmp_classify #(.EXP_W(EW), .FRAC_W(FW)) u_cls_b (
            .x   (job.b[W-1:0]),
            .cls (cls_b)
        );
        fcmp_order #(.W(W)) u_ord (
            .a  (job.a[W-1:0]),
            .b  (job.b[W-1:0]),
            .gt (gt_w),
            .eq (eq_w)
        );

        assign nan_any[f]  = cls_a.is_nan  | cls_b.is_nan;
        assign snan_any[f] = cls_a.is_snan | cls_b.is_snan;
        assign gt_f[f]     = gt_w;
        assign eq_f[f]     = eq_w;
    end

    logic sel_nan, sel_snan, sel_gt, sel_eq;

    always_comb begin
        sel_nan     = nan_any[job.dbl];
        sel_snan    = snan_any[job.dbl];
        sel_gt      = gt_f[job.dbl];
        sel_eq      = eq_f[job.dbl];
        res.invalid = sel_snan || ((job.kind == CMP_GT) && sel_nan);
        if (sel_nan)
            res.t = 1'b0;
        else
            res.t = (job.kind == CMP_GT) ? sel_gt : sel_eq;
    end
endmodule

// File: rtl/fcmp_seq.sv
module fcmp_seq
    import fcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OPC_W-1:0]  opcode,
    input  logic              prec_dbl,
    input  logic [DATA_W-1:0] op_n,
    input  logic [DATA_W-1:0] op_m,
    output cmp_job_t          job,
    output logic              accept,
    output logic              write_en,
    output logic              busy
);
    cmp_job_t live, held;
    logic     legal;

    always_comb begin
        live.kind = op_kind(opcode);
        live.dbl  = prec_dbl;
        live.a    = op_n;
        live.b    = op_m;
        legal     = op_is_cmp(opcode) && (!prec_dbl || regs_even(opcode));
        accept    = start && legal && !busy;
        write_en  = (accept && !prec_dbl) || busy;
        job       = busy ? held : live;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            held <= '0;
        end else begin
            busy <= accept && prec_dbl;
            if (accept && prec_dbl)
                held <= live;
        end
    end
endmodule

// File: rtl/fp_compare_unit.sv
module fp_compare_unit
    import fcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OPC_W-1:0]  opcode,
    input  logic              prec_dbl,
    input  logic [DATA_W-1:0] op_n,
    input  logic [DATA_W-1:0] op_m,
    input  logic              inv_trap_en,
    output logic              done,
    output logic              tflag,
    output logic              cause_invalid,
    output logic              sticky_invalid,
    output logic              exc_req
);
    cmp_job_t job;
    cmp_res_t res;
    logic     accept, write_en, busy;

    fcmp_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .opcode   (opcode),
        .prec_dbl (prec_dbl),
        .op_n     (op_n),
        .op_m     (op_m),
        .job      (job),
        .accept   (accept),
        .write_en (write_en),
        .busy     (busy)
    );

    fcmp_eval u_eval (
        .job (job),
        .res (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done           <= 1'b0;
            tflag          <= 1'b0;
            cause_invalid  <= 1'b0;
            sticky_invalid <= 1'b0;
            exc_req        <= 1'b0;
        end else begin
            done    <= write_en;
            exc_req <= 1'b0;
            if (accept)
                cause_invalid <= 1'b0;
            if (write_en) begin
                if (res.invalid) begin
                    cause_invalid <= 1'b1;
                    if (inv_trap_en) begin
                        exc_req <= 1'b1;
                    end else begin
                        sticky_invalid <= 1'b1;
                        tflag          <= 1'b0;
                    end
                end else begin
                    cause_invalid <= 1'b0;
                    tflag         <= res.t;
                end
            end
        end
    end
endmodule

// File: rtl/fcmp_chk.sv
module fcmp_chk
    import fcmp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [OPC_W-1:0] opcode,
    input logic             prec_dbl,
    input logic             busy,
    input logic             done,
    input logic             tflag,
    input logic             cause_invalid,
    input logic             sticky_invalid,
    input logic             exc_req
);
    AST_SGL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        start && !prec_dbl && op_is_cmp(opcode) && !busy |=> done); // R4
    AST_DBL_TWO_CYCLE: assert property (@(posedge clk) disable iff (rst)
        start && prec_dbl && op_is_cmp(opcode) && regs_even(opcode) && !busy |=> !done ##1 done); // R4
    AST_ODD_PAIR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        start && prec_dbl && !regs_even(opcode) && !busy |=> !done); // R3
    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy); // R12
    AST_TRAP_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> done && cause_invalid && (tflag == $past(tflag))); // R10
    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        sticky_invalid |=> sticky_invalid); // R9
    AST_CAUSE_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(cause_invalid) |-> done); // R11
endmodule

bind fp_compare_unit fcmp_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .start          (start),
    .opcode         (opcode),
    .prec_dbl       (prec_dbl),
    .busy           (busy),
    .done           (done),
    .tflag          (tflag),
    .cause_invalid  (cause_invalid),
    .sticky_invalid (sticky_invalid),
    .exc_req        (exc_req)
);

// File: tb/fp_compare_unit_tb.sv
module fp_compare_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] opcode = '0;
    logic        prec_dbl = 1'b0;
    logic [63:0] op_n = '0, op_m = '0;
    logic        inv_trap_en = 1'b0;
    logic        done, tflag, cause_invalid, sticky_invalid, exc_req;

    int checks = 0;
    int failures = 0;
    bit ended = 0;
    bit sticky_m = 0;

    always #5 clk = ~clk;

    fp_compare_unit u_dut (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .prec_dbl(prec_dbl),
        .op_n(op_n), .op_m(op_m), .inv_trap_en(inv_trap_en), .done(done), .tflag(tflag),
        .cause_invalid(cause_invalid), .sticky_invalid(sticky_invalid), .exc_req(exc_req)
    );

    localparam logic [63:0] S1 = 64'h3F800000, S2 = 64'h40000000;
    localparam logic [63:0] SN1 = 64'hBF800000, SN2 = 64'hC0000000;
    localparam logic [63:0] SNZ = 64'h80000000, SQN = 64'h7FC00000;
    localparam logic [63:0] SSN = 64'h7F800001, SINF = 64'h7F800000;
    localparam logic [63:0] D1 = 64'h3FF0000000000000, D2 = 64'h4000000000000000;
    localparam logic [63:0] DN1 = 64'hBFF0000000000000, DN2 = 64'hC000000000000000;
    localparam logic [63:0] DNZ = 64'h8000000000000000, DQN = 64'h7FF8000000000000;
    localparam logic [63:0] DSN = 64'h7FF0000000000001;
    localparam logic [15:0] OP_EQ = 16'hF244, OP_GT = 16'hF245;

    typedef struct packed {
        logic        dbl;
        logic        gt;
        logic [63:0] n;
        logic [63:0] m;
        logic        t;
        logic        inv;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 64'hDEADBEEF_3F800000, 64'h12345678_3F800000, 1'b1, 1'b0},
        '{1'b0, 1'b0, S1,  S2,  1'b0, 1'b0},
        '{1'b0, 1'b1, S2,  S1,  1'b1, 1'b0},
        '{1'b0, 1'b1, S1,  S2,  1'b0, 1'b0},
        '{1'b0, 1'b1, SN1, SN2, 1'b1, 1'b0},
        '{1'b0, 1'b1, SN2, SN1, 1'b0, 1'b0},
        '{1'b0, 1'b0, 64'h0, SNZ, 1'b1, 1'b0},
        '{1'b0, 1'b1, 64'h0, SNZ, 1'b0, 1'b0},
        '{1'b0, 1'b1, S1,  SN1, 1'b1, 1'b0},
        '{1'b0, 1'b1, 64'h2, 64'h1, 1'b1, 1'b0},
        '{1'b0, 1'b0, SQN, SQN, 1'b0, 1'b0},
        '{1'b0, 1'b1, SQN, S1,  1'b0, 1'b1},
        '{1'b0, 1'b0, SSN, S1,  1'b0, 1'b1},
        '{1'b0, 1'b1, SINF, S2, 1'b1, 1'b0},
        '{1'b1, 1'b0, D1,  D1,  1'b1, 1'b0},
        '{1'b1, 1'b1, D2,  D1,  1'b1, 1'b0},
        '{1'b1, 1'b1, DN1, DN2, 1'b1, 1'b0},
        '{1'b1, 1'b0, 64'h0, DNZ, 1'b1, 1'b0},
        '{1'b1, 1'b0, DQN, DQN, 1'b0, 1'b0},
        '{1'b1, 1'b1, D1,  DQN, 1'b0, 1'b1},
        '{1'b1, 1'b0, DSN, DSN, 1'b0, 1'b1},
        '{1'b1, 1'b1, 64'h1, 64'h0, 1'b1, 1'b0}
    };

    function automatic string tag_of(int i);
        case (i)
            0: return "R1";
            1, 6, 9: return "R5";
            10, 11, 18, 19: return "R7";
            12, 20: return "R8";
            14, 15: return "R1";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_cmp(input bit dbl, input bit gt, input logic [63:0] n, input logic [63:0] m,
                           input bit exp_t, input bit exp_inv, input string tag);
        @(negedge clk);
        start = 1'b1; opcode = gt ? OP_GT : OP_EQ; prec_dbl = dbl; op_n = n; op_m = m;
        @(negedge clk);
        start = 1'b0; op_n = '0; op_m = '0;
        if (exp_inv) sticky_m = 1'b1;
        if (dbl) begin
            chk(done == 1'b0, "R4 dbl first cycle", done, 0);
            chk(cause_invalid == 1'b0, "R11 cleared at start", cause_invalid, 0);
            @(negedge clk);
        end
        chk(done == 1'b1, "R4 done", done, 1);
        chk(tflag == exp_t, {tag, " tflag"}, tflag, exp_t);
        chk(cause_invalid == exp_inv, {tag, " R11 cause"}, cause_invalid, exp_inv);
        chk(exc_req == 1'b0, "R9 no exc", exc_req, 0);
        chk(sticky_invalid == sticky_m, "R9 sticky", sticky_invalid, sticky_m);
        @(negedge clk);
        chk(done == 1'b0, "R4 pulse", done, 0);
    endtask

    task automatic ignored_start(input bit dbl, input logic [15:0] op, input string req,
                                 input bit t_exp, input bit c_exp);
        @(negedge clk);
        start = 1'b1; opcode = op; prec_dbl = dbl; op_n = S1; op_m = S2;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, req, done, 0);
        @(negedge clk);
        chk(done == 1'b0, req, done, 0);
        chk(tflag == t_exp, req, tflag, t_exp);
        chk(cause_invalid == c_exp, req, cause_invalid, c_exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({done, tflag, cause_invalid, sticky_invalid, exc_req} == 5'b0, "R13 reset",
            {done, tflag, cause_invalid, sticky_invalid, exc_req}, 0);

        // R10 trap path, with the sticky bit still clear
        run_cmp(1'b0, 1'b0, S1, S1, 1'b1, 1'b0, "R5");
        inv_trap_en = 1'b1;
        @(negedge clk);
        start = 1'b1; opcode = OP_EQ; prec_dbl = 1'b0; op_n = SSN; op_m = S1;
        @(negedge clk);
        start = 1'b0;
        chk(done && exc_req, "R10 exc pulse", {done, exc_req}, 2'b11);
        chk(tflag == 1'b1, "R10 flag kept", tflag, 1);
        chk(cause_invalid == 1'b1, "R10 cause", cause_invalid, 1);
        chk(sticky_invalid == 1'b0, "R10 sticky kept", sticky_invalid, 0);
        @(negedge clk);
        chk(exc_req == 1'b0, "R10 one cycle", exc_req, 0);
        inv_trap_en = 1'b0;

        ignored_start(1'b0, 16'hF006, "R2 bad opcode", 1'b1, 1'b1);
        ignored_start(1'b0, 16'hE244, "R2 bad prefix", 1'b1, 1'b1);
        ignored_start(1'b1, 16'hF144, "R3 odd n", 1'b1, 1'b1);
        ignored_start(1'b1, 16'hF214, "R3 odd m", 1'b1, 1'b1);

        for (int i = 0; i < NV; i++)
            run_cmp(VEC[i].dbl, VEC[i].gt, VEC[i].n, VEC[i].m, VEC[i].t, VEC[i].inv, tag_of(i));

        // R12: second start during a double compare is dropped
        run_cmp(1'b0, 1'b0, S1, S2, 1'b0, 1'b0, "R5");
        @(negedge clk);
        start = 1'b1; opcode = OP_EQ; prec_dbl = 1'b1; op_n = D1; op_m = D1;
        @(negedge clk);
        opcode = OP_GT; prec_dbl = 1'b0; op_n = SSN; op_m = S1;
        chk(done == 1'b0, "R12 busy", done, 0);
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1 && tflag == 1'b1, "R12 double result", {done, tflag}, 2'b11);
        chk(cause_invalid == 1'b0, "R12 cause", cause_invalid, 0);
        @(negedge clk);
        chk(done == 1'b0 && cause_invalid == 1'b0 && tflag == 1'b1, "R12 ignored",
            {done, cause_invalid, tflag}, 3'b001);

        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule